// File: doc/BRIEF.md
# SIMD Immediate Shift Unit

This block decodes and executes vector shift-by-immediate operations on a 128-bit operand. Each cycle it may accept one 32-bit operation word with a 128-bit source vector, qualified by a valid strobe. It recognises three operations: shift left, arithmetic (signed) shift right and logical (unsigned) shift right. The operand is split into independent lanes of 8, 16 or 32 bits, and every lane is shifted by the same count.

Both the lane width and the shift count come from a single packed 6-bit immediate. The leading one of that immediate selects the lane width. The remaining offset gives the count, and left and right shifts use opposite offset rules. The result is registered with one cycle of latency. It is returned together with the destination and source register numbers carried in the operation word. Encodings that cannot be executed raise an illegal flag instead of producing a result.

Top module: `simd_shimm_unit`

## Requirements
- R1: The immediate is `op_word[21:16]`. A value of 8..15 selects 8-bit lanes, 16..31 selects 16-bit lanes and 32..63 selects 32-bit lanes.
- R2: Shift left is encoded by `op_word[11:7]` = 5'b01010, `op_word[4]` = 1 and `op_word[6]` = 1. The count is the immediate minus the lane width (0 to width-1), and vacated low bits are zero. `op_word[24]` has no effect on a left shift.
- R3: Shift right is encoded by `op_word[11:7]` = 5'b00000, `op_word[4]` = 1 and `op_word[6]` = 1. The count is twice the lane width minus the immediate (1 to width). With `op_word[24]` = 1 the shift is logical and vacated high bits are zero.
- R4: With `op_word[24]` = 0, a right shift is arithmetic: vacated high bits take the lane's sign bit.
- R5: A right shift by the full lane width gives all zeros in a logical lane. In an arithmetic lane it gives every bit equal to that lane's sign bit.
- R6: Lanes are independent. Bits shifted out of one lane are dropped and never appear in a neighbouring lane.
- R7: `dst_reg` is {`op_word[22]`, `op_word[15:12]`} and `src_reg` is {`op_word[5]`, `op_word[3:0]`}. Both are presented with the result of the same operation.
- R8: An operation is illegal when any of these holds: the immediate is below 8, `op_word[4]` = 0, `op_word[6]` = 0, or `op_word[11:7]` matches neither form. An illegal operation raises `illegal` with `out_valid` and leaves `result`, `dst_reg` and `src_reg` unchanged.
- R9: `out_valid` is `in_valid` delayed by exactly one clock. `illegal` is only high together with `out_valid`. `result` holds its value while no operation completes.
- R10: A synchronous active-high reset clears `out_valid`, `illegal`, `result`, `dst_reg` and `src_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation word and source vector are valid |
| op_word | input | 32 | Operation word |
| src_vec | input | 128 | Source vector |
| out_valid | output | 1 | Registered result cycle |
| illegal | output | 1 | Operation of the previous cycle was not executable |
| result | output | 128 | Shifted vector |
| dst_reg | output | 5 | Destination register number |
| src_reg | output | 5 | Source register number |

## Verification
A wrong lane-width decode or a wrong offset rule shows up in the very next cycle as a shifted vector that differs from the per-lane reference. For the plain splat patterns, this appears as a shift by the wrong count or across the wrong lane boundaries. Bad fill selection or carry between lanes shows up first on negative lanes and on full-width right shifts. A broken hold path shows up on the cycle after an illegal or idle input, as a result or register number that moved when it should have stayed.

// File: rtl/simd_shimm_pkg.sv
package simd_shimm_pkg;
    localparam int VEC_W    = 128;
    localparam int WORD_W   = 32;
    localparam int IMM_LO   = 16;
    localparam int IMM_W    = 6;
    localparam int CNT_W    = 6;
    localparam int REG_W    = 5;
    localparam int NUM_SZ   = 3;
    localparam int MIN_LANE = 8;

    typedef enum logic [1:0] {
        LANE8  = 2'd0,
        LANE16 = 2'd1,
        LANE32 = 2'd2
    } lane_sz_e;

    typedef struct packed {
        logic             legal;
        logic             left;
        logic             arith;
        lane_sz_e         sz;
        logic [CNT_W-1:0] count;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
    } shimm_dec_t;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] result;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
    } shimm_state_t;
endpackage

// File: rtl/simd_shimm_decode.sv
module simd_shimm_decode
    import simd_shimm_pkg::*;
(
    input  logic [WORD_W-1:0] op_word,
    output shimm_dec_t        dec
);
    localparam int EXT_W = IMM_W + 1;

    logic [IMM_W-1:0] imm;
    logic [EXT_W-1:0] imm_ext;
    logic [EXT_W-1:0] width_ext;
    logic [EXT_W-1:0] cnt_ext;
    logic             form_left;
    logic             form_right;
    logic             imm_ok;
    logic             unused_bits;

    assign imm         = op_word[IMM_LO +: IMM_W];
    assign imm_ext     = {1'b0, imm};
    assign form_left   = (op_word[11:7] == 5'b01010);
    assign form_right  = (op_word[11:7] == 5'b00000);
    assign imm_ok      = |imm[IMM_W-1:3];
    assign unused_bits = ^{op_word[31:25], op_word[23], cnt_ext[EXT_W-1]};

    always_comb begin
        dec = '0;
        if (imm[5]) begin
            dec.sz    = LANE32;
            width_ext = EXT_W'(32);
        end else if (imm[4]) begin
            dec.sz    = LANE16;
            width_ext = EXT_W'(16);
        end else begin
            dec.sz    = LANE8;
            width_ext = EXT_W'(MIN_LANE);
        end
        if (form_left)
            cnt_ext = imm_ext - width_ext;
        else
            cnt_ext = (width_ext << 1) - imm_ext;
        dec.count = cnt_ext[CNT_W-1:0];
        dec.left  = form_left;
        dec.arith = ~op_word[24];
        dec.legal = imm_ok & op_word[4] & op_word[6] & (form_left | form_right);
        dec.dst   = {op_word[22], op_word[15:12]};
        dec.src   = {op_word[5],  op_word[3:0]};
    end
endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic [VEC_W-1:0] vec_in,
    input  logic [CNT_W-1:0] count,
    input  logic             left,
    input  logic             arith,
    output logic [VEC_W-1:0] vec_out
);
    localparam int LANES = VEC_W / LANE_W;
    localparam int EXT_W = 2 * LANE_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane;
        logic              fill;
        logic [EXT_W-1:0]  ext;
        logic [EXT_W-1:0]  shr;
        logic [LANE_W-1:0] shl;
        logic              unused_hi;

        assign lane      = vec_in[l*LANE_W +: LANE_W];
        assign fill      = arith & lane[LANE_W-1];
        assign ext       = {{LANE_W{fill}}, lane};
        assign shr       = ext >> count;
        assign shl       = lane << count;
        assign unused_hi = ^shr[EXT_W-1:LANE_W];
        assign vec_out[l*LANE_W +: LANE_W] = left ? shl : shr[LANE_W-1:0];
    end
endmodule

// File: rtl/simd_shimm_unit.sv
module simd_shimm_unit
    import simd_shimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       op_word,
    input  logic [127:0]      src_vec,
    output logic              out_valid,
    output logic              illegal,
    output logic [127:0]      result,
    output logic [4:0]        dst_reg,
    output logic [4:0]        src_reg
);
    shimm_dec_t   dec;
    shimm_state_t st_d;
    shimm_state_t st_q;
    logic [VEC_W-1:0] shifted [NUM_SZ];

    simd_shimm_decode u_dec (
        .op_word (op_word),
        .dec     (dec)
    );

    for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
        localparam int LW = MIN_LANE << g;
        simd_lane_shift #(
            .VEC_W  (VEC_W),
            .LANE_W (LW),
            .CNT_W  (CNT_W)
        ) u_shift (
            .vec_in  (src_vec),
            .count   (dec.count),
            .left    (dec.left),
            .arith   (dec.arith),
            .vec_out (shifted[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.illegal = 1'b0;
        if (in_valid) begin
            if (dec.legal) begin
                st_d.result = shifted[int'(dec.sz)];
                st_d.dst    = dec.dst;
                st_d.src    = dec.src;
            end else begin
                st_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign illegal   = st_q.illegal;
    assign result    = st_q.result;
    assign dst_reg   = st_q.dst;
    assign src_reg   = st_q.src;
endmodule

// File: rtl/simd_shimm_chk.sv
module simd_shimm_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic         illegal,
    input logic [127:0] result,
    input logic [4:0]   dst_reg,
    input logic [4:0]   src_reg
);
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && !rst));

    assert_flag_qual_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> out_valid);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(result));

    assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($stable(result) && $stable(dst_reg) && $stable(src_reg)));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst_seen_q |-> (!out_valid && !illegal && result == '0));
endmodule

bind simd_shimm_unit simd_shimm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .illegal   (illegal),
    .result    (result),
    .dst_reg   (dst_reg),
    .src_reg   (src_reg)
);

// File: tb/sim_simd_shimm_unit.sv
module sim_simd_shimm_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  op_word = '0;
    logic [127:0] src_vec = '0;
    logic         out_valid;
    logic         illegal;
    logic [127:0] result;
    logic [4:0]   dst_reg;
    logic [4:0]   src_reg;

    int checks = 0;
    int errors = 0;
    logic [127:0] exp_res = '0;
    logic [4:0]   exp_dst = '0;
    logic [4:0]   exp_src = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_shimm_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_word(op_word),
        .src_vec(src_vec), .out_valid(out_valid), .illegal(illegal),
        .result(result), .dst_reg(dst_reg), .src_reg(src_reg)
    );

    function automatic logic [31:0] mk(input bit left, input bit uns,
                                       input int imm, input int d, input int m);
        logic [31:0] w = 32'hF2800000;
        w[21:16] = imm[5:0];
        w[24]    = uns;
        w[22]    = d[4];
        w[15:12] = d[3:0];
        w[5]     = m[4];
        w[3:0]   = m[3:0];
        w[6]     = 1'b1;
        w[4]     = 1'b1;
        w[11:7]  = left ? 5'b01010 : 5'b00000;
        return w;
    endfunction

    function automatic bit ref_legal(input logic [31:0] w);
        return w[4] && w[6] && (w[21:16] >= 6'd8) &&
               (w[11:7] == 5'b01010 || w[11:7] == 5'b00000);
    endfunction

    function automatic logic [127:0] ref_shift(input logic [31:0] w, input logic [127:0] v);
        int imm = int'(w[21:16]);
        int wd  = (imm >= 32) ? 32 : (imm >= 16) ? 16 : 8;
        bit lf  = (w[11:7] == 5'b01010);
        int c   = lf ? imm - wd : 2*wd - imm;
        logic [127:0] r = '0;
        for (int i = 0; i < 128/wd; i++) begin
            logic [31:0] x = '0;
            logic [31:0] y;
            logic        sg;
            for (int b = 0; b < wd; b++) x[b] = v[i*wd+b];
            sg = x[wd-1];
            if (lf) y = x << c;
            else begin
                y = x >> c;
                if (!w[24] && sg)
                    for (int b = wd - c; b < wd; b++) y[b] = 1'b1;
            end
            for (int b = 0; b < wd; b++) r[i*wd+b] = y[b];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [127:0] v, input string req);
        bit lg = ref_legal(w);
        @(negedge clk);
        in_valid = 1'b1; op_word = w; src_vec = v;
        @(negedge clk);
        in_valid = 1'b0;
        if (lg) begin
            exp_res = ref_shift(w, v);
            exp_dst = {w[22], w[15:12]};
            exp_src = {w[5], w[3:0]};
        end
        chk(out_valid == 1'b1, {req, " R9 valid"}, 128'(out_valid), 128'(1));
        chk(illegal == !lg, {req, " R8 flag"}, 128'(illegal), 128'(!lg));
        chk(result == exp_res, req, result, exp_res);
        chk(dst_reg == exp_dst && src_reg == exp_src, {req, " R7 regs"},
            128'({dst_reg, src_reg}), 128'({exp_dst, exp_src}));
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk(out_valid == 1'b0 && illegal == 1'b0, "R9 idle valid",
            128'({out_valid, illegal}), 128'(0));
        chk(result == exp_res, "R9 idle hold", result, exp_res);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [127:0] p55 = {16{8'h55}};
        logic [127:0] p80 = {16{8'h80}};
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk(out_valid == 0 && illegal == 0 && result == '0 && dst_reg == 0 && src_reg == 0,
            "R10 reset", result, 128'(0));

        // R1 R2 left shifts across widths
        run_op(mk(1, 0, 8 + 1, 31, 0), p55, "R2 left8");
        chk(result == {16{8'hAA}}, "R1 splat8", result, {16{8'hAA}});
        run_op(mk(1, 1, 16 + 9, 31, 0), p55, "R2 left16 bit24 ignored");
        chk(result == {8{16'hAA00}}, "R1 splat16", result, {8{16'hAA00}});
        run_op(mk(1, 0, 32 + 17, 31, 0), p55, "R2 left32");
        chk(result == {4{32'hAAAA0000}}, "R1 splat32", result, {4{32'hAAAA0000}});
        idle_check();

        // R3 R4 right shifts
        run_op(mk(0, 0, 16 - 1, 3, 17), p80, "R4 asr8");
        chk(result == {16{8'hC0}}, "R4 splat", result, {16{8'hC0}});
        run_op(mk(0, 1, 32 - 9, 12, 5), p80, "R3 lsr16");
        chk(result == {8{16'h0040}}, "R3 splat", result, {8{16'h0040}});
        run_op(mk(0, 0, 64 - 17, 20, 9), p80, "R4 asr32");
        chk(result == {4{32'hFFFFC040}}, "R4 splat32", result, {4{32'hFFFFC040}});

        // R5 full-width right shifts
        run_op(mk(0, 1, 8, 1, 2), {16{8'hF3}}, "R5 lsr8 full");
        chk(result == '0, "R5 zero", result, '0);
        run_op(mk(0, 0, 32, 1, 2), {4{32'h8001_7FFF}}, "R5 asr32 full");
        chk(result == {4{32'hFFFFFFFF}}, "R5 sign", result, {4{32'hFFFFFFFF}});
        run_op(mk(0, 0, 16, 4, 4), {8{16'h8000}} ^ {4{32'h8000_0000}}, "R5 asr16 mixed");

        // R6 lane isolation
        run_op(mk(1, 0, 8 + 7, 6, 7), {16{8'hFF}}, "R6 left8 by7");
        chk(result == {16{8'h80}}, "R6 no carry", result, {16{8'h80}});
        run_op(mk(0, 1, 16 - 7, 6, 7), {16{8'hFF}}, "R6 lsr8 by7");
        chk(result == {16{8'h01}}, "R6 no borrow", result, {16{8'h01}});

        // R8 illegal encodings hold state
        run_op(mk(1, 0, 7, 9, 9), p55, "R8 imm below 8");
        run_op(mk(1, 0, 20, 9, 9) & ~32'h40, p55, "R8 no quad bit");
        run_op(mk(0, 0, 20, 9, 9) & ~32'h10, p55, "R8 bit4 clear");
        run_op(mk(0, 0, 20, 9, 9) | 32'h80, p55, "R8 bad form");
        idle_check();

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0]  w;
            logic [127:0] v = {$urandom, $urandom, $urandom, $urandom};
            if ($urandom_range(0, 7) == 0) w = $urandom;
            else w = mk($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                        $urandom_range(8, 63), $urandom_range(0, 31), $urandom_range(0, 31));
            run_op(w, v, "R6 random");
            if ($urandom_range(0, 9) == 0) idle_check();
        end

        // R10 reset mid-stream
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op_word = mk(1, 0, 9, 1, 1); src_vec = p55;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        exp_res = '0; exp_dst = '0; exp_src = '0;
        chk(out_valid == 0 && illegal == 0 && result == '0 && dst_reg == 0,
            "R10 reset clear", result, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule